// File: doc/BRIEF.md
# Clock Generator Operating Mode Sequencer

This block is the control state machine that steps a clock generator between four operating modes: pass-through (bypass), frequency multiply, loop powerdown and full powerdown. It receives software mode requests on a simple write strobe. It also receives an asynchronous wake-up event, a lock flag from the analog loop, and three boot-strap inputs. From these it drives a 2-bit mode code for the clock mux, an enable for the analog loop, an input-divider enable and the multiplier value used by the loop.

The strap inputs are sampled once, on the first clock edge after reset is released, and are then frozen. When the strap input for pass-through is 0, the block arms a multiply request right after reset and enters multiply mode when the loop reports lock. Before entering full powerdown the block records whether it was multiplying. On wake-up it uses that record and a software control bit to choose the mode it resumes in. A device that was multiplying resumes in bypass and returns to multiply by itself once lock is seen again.

Top module: `pll_mode_ctrl`

## Requirements
- R1: While reset is asserted, modeCode is 00 (bypass), pllEnable is 1, divEnable is 0 and mulValue is 0.
- R2: On the first rising edge after reset release, divEnable takes the value of strapDiv2 and mulValue takes strapMulSel. Later changes on any strap input have no effect on the outputs until the next reset.
- R3: When the captured strapBypass is 1, mulValue reads 0 and a multiply request (code 01) is ignored: the mode stays as it was, even with pllLock high.
- R4: Mode codes are 00 bypass, 01 multiply, 10 loop powerdown and 11 full powerdown. pllEnable is 1 exactly in codes 00 and 01.
- R5: A write (cfgWrEn=1) requesting bypass (00) or loop powerdown (10) outside full powerdown changes modeCode on the same rising edge and cancels any pending multiply.
- R6: A multiply write with pllLock=1 enters code 01 on that edge. With pllLock=0 the block goes to bypass with the request pending, and enters 01 on the first edge where pllLock is 1.
- R7: When the captured strapBypass is 0, a multiply request is armed automatically after reset and is completed on the first edge with pllLock=1.
- R8: A write of code 11 enters full powerdown on that edge and records whether the mode was 01. While in full powerdown, writes have no effect.
- R9: wakeAsync passes through a two-flop synchronizer. The mode leaves full powerdown on the third rising edge after wakeAsync is first sampled high, and not before.
- R10: On wake-up the block goes to bypass with multiply pending if it was in 01 before powerdown. Otherwise it goes to bypass if the off bit (cfgPllOff, sampled with every accepted write) is 1, and to loop powerdown (10) if that bit is 0.
- R11: The mode never goes from any other code to 01 on an edge where pllLock is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Mode request write strobe |
| cfgModeReq | input | 2 | Requested mode code |
| cfgPllOff | input | 1 | Off bit that picks the wake-up mode, sampled with each accepted write |
| wakeAsync | input | 1 | Asynchronous wake-up event |
| pllLock | input | 1 | Lock flag from the analog loop |
| strapBypass | input | 1 | Strap: pass the input clock straight through |
| strapDiv2 | input | 1 | Strap: divide the input clock by two |
| strapMulSel | input | 7 | Strap: multiplier ratio select |
| modeCode | output | 2 | Current mode code for the clock mux |
| pllEnable | output | 1 | Analog loop enable |
| divEnable | output | 1 | Input divider enable |
| mulValue | output | 7 | Multiplier value for the loop, 0 when bypass is strapped |

## Verification
Mode writes and lock-driven moves into multiply show on modeCode one rising edge after the inputs are driven. The strap outputs settle on the first edge after reset release. A wake-up shows on the third edge, counting both synchronizer flops and the state register. The bench drives inputs on falling edges and samples outputs on the falling edge after the edge where the result is due. For wake-up it also samples on the two earlier falling edges and checks that the mode has not yet moved.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;

  typedef enum logic [1:0] {
    MODE_BYP    = 2'b00,
    MODE_MUL    = 2'b01,
    MODE_LOOPPD = 2'b10,
    MODE_FULLPD = 2'b11
  } modeT;

  // control -> datapath
  typedef struct packed {
    logic wrCfg;     // accepted write: sample the off bit
    logic saveMode;  // entering full powerdown: record prior mode
    logic savedMul;  // prior mode was multiply
  } ctrlStrobesT;

  // datapath -> control
  typedef struct packed {
    logic firstCycle; // strap capture edge
    logic strapByp;   // bypass strap (live on capture edge, frozen after)
    logic wakeSync;   // synchronized wake event
    logic pllOff;     // stored off bit
    logic wasMul;     // recorded prior mode
  } dpStatusT;

endpackage

// File: rtl/pll_mode_dp.sv
module pll_mode_dp
  import pll_mode_pkg::*;
#(
  parameter int MUL_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapBypass,
  input  logic              strapDiv2,
  input  logic [MUL_W-1:0]  strapMulSel,
  input  logic              wakeAsync,
  input  logic              cfgPllOff,
  input  ctrlStrobesT       strobes,
  output dpStatusT          status,
  output logic              divEnable,
  output logic [MUL_W-1:0]  mulValue
);

  localparam int SYNC_LAST = SYNC_STAGES - 1;

  logic             capDone;
  logic             bypQ;
  logic             divQ;
  logic [MUL_W-1:0] mulQ;
  logic             pllOffQ;
  logic             wasMulQ;
  logic [SYNC_LAST:0] syncQ;

  // strap capture, once per reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capDone <= 1'b0;
      bypQ    <= 1'b0;
      divQ    <= 1'b0;
      mulQ    <= '0;
    end else if (!capDone) begin
      capDone <= 1'b1;
      bypQ    <= strapBypass;
      divQ    <= strapDiv2;
      mulQ    <= strapMulSel;
    end
  end

  // wake synchronizer
  generate
    if (SYNC_STAGES > 1) begin : g_syncChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_LAST-1:0], wakeAsync};
      end
    end else begin : g_syncSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= wakeAsync;
      end
    end
  endgenerate

  // configuration and prior-mode record
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pllOffQ <= 1'b0;
      wasMulQ <= 1'b0;
    end else begin
      if (strobes.wrCfg)    pllOffQ <= cfgPllOff;
      if (strobes.saveMode) wasMulQ <= strobes.savedMul;
    end
  end

  always_comb begin
    status.firstCycle = !capDone;
    status.strapByp   = capDone ? bypQ : strapBypass;
    status.wakeSync   = syncQ[SYNC_LAST];
    status.pllOff     = pllOffQ;
    status.wasMul     = wasMulQ;
  end

  assign divEnable = divQ;
  assign mulValue  = bypQ ? '0 : mulQ;

endmodule

// File: rtl/pll_mode_fsm.sv
module pll_mode_fsm
  import pll_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [1:0]  cfgModeReq,
  input  logic        pllLock,
  input  dpStatusT    status,
  output ctrlStrobesT strobes,
  output logic [1:0]  modeCode,
  output logic        pllEnable
);

  modeT mode, nMode;
  logic pendMul, nPendMul;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= MODE_BYP;
      pendMul <= 1'b0;
    end else begin
      mode    <= nMode;
      pendMul <= nPendMul;
    end
  end

  always_comb begin
    nMode    = mode;
    nPendMul = pendMul;
    strobes  = '0;
    if (status.firstCycle) begin
      nPendMul = !status.strapByp;
    end else if (mode == MODE_FULLPD) begin
      if (status.wakeSync) begin
        if (status.wasMul) begin
          nMode    = MODE_BYP;
          nPendMul = 1'b1;
        end else if (status.pllOff) begin
          nMode = MODE_BYP;
        end else begin
          nMode = MODE_LOOPPD;
        end
      end
    end else if (cfgWrEn) begin
      strobes.wrCfg = 1'b1;
      unique case (modeT'(cfgModeReq))
        MODE_BYP: begin
          nMode    = MODE_BYP;
          nPendMul = 1'b0;
        end
        MODE_MUL: begin
          if (!status.strapByp) begin
            if (pllLock) begin
              nMode    = MODE_MUL;
              nPendMul = 1'b0;
            end else begin
              nMode    = MODE_BYP;
              nPendMul = 1'b1;
            end
          end
        end
        MODE_LOOPPD: begin
          nMode    = MODE_LOOPPD;
          nPendMul = 1'b0;
        end
        MODE_FULLPD: begin
          strobes.saveMode = 1'b1;
          strobes.savedMul = (mode == MODE_MUL);
          nMode            = MODE_FULLPD;
          nPendMul         = 1'b0;
        end
        default: ;
      endcase
    end else if (mode == MODE_BYP && pendMul && pllLock) begin
      nMode    = MODE_MUL;
      nPendMul = 1'b0;
    end
  end

  assign modeCode  = mode;
  assign pllEnable = (mode == MODE_BYP) || (mode == MODE_MUL);

endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl
  import pll_mode_pkg::*;
#(
  parameter int MUL_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgModeReq,
  input  logic             cfgPllOff,
  input  logic             wakeAsync,
  input  logic             pllLock,
  input  logic             strapBypass,
  input  logic             strapDiv2,
  input  logic [MUL_W-1:0] strapMulSel,
  output logic [1:0]       modeCode,
  output logic             pllEnable,
  output logic             divEnable,
  output logic [MUL_W-1:0] mulValue
);

  ctrlStrobesT strobes;
  dpStatusT    status;

  pll_mode_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgModeReq (cfgModeReq),
    .pllLock    (pllLock),
    .status     (status),
    .strobes    (strobes),
    .modeCode   (modeCode),
    .pllEnable  (pllEnable)
  );

  pll_mode_dp #(.MUL_W(MUL_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strapBypass (strapBypass),
    .strapDiv2   (strapDiv2),
    .strapMulSel (strapMulSel),
    .wakeAsync   (wakeAsync),
    .cfgPllOff   (cfgPllOff),
    .strobes     (strobes),
    .status      (status),
    .divEnable   (divEnable),
    .mulValue    (mulValue)
  );

endmodule

// File: rtl/pll_mode_ctrl_chk.sv
module pll_mode_ctrl_chk #(
  parameter int MUL_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       modeCode,
  input logic             pllEnable,
  input logic             pllLock,
  input logic             wakeAsync,
  input logic             divEnable,
  input logic [MUL_W-1:0] mulValue
);

  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R11
  no_mul_without_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode != 2'b01 && !pllLock) |=> modeCode != 2'b01);

  // R4
  loop_off_in_powerdown_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeCode[1] |-> !pllEnable);

  // R9
  wake_needed_to_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 2'b11) |=> (modeCode == 2'b11 || $past(wakeAsync, 3)));

  // R10
  wake_not_to_mul_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 2'b11) |=> modeCode != 2'b01);

  // R2
  straps_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> ($stable(divEnable) && $stable(mulValue)));

endmodule

bind pll_mode_ctrl pll_mode_ctrl_chk #(.MUL_W(MUL_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .modeCode  (modeCode),
  .pllEnable (pllEnable),
  .pllLock   (pllLock),
  .wakeAsync (wakeAsync),
  .divEnable (divEnable),
  .mulValue  (mulValue)
);

// File: tb/pll_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pll_mode_ctrl_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [1:0] cfgModeReq = 2'b00;
  logic       cfgPllOff = 1'b0;
  logic       wakeAsync = 1'b0;
  logic       pllLock = 1'b0;
  logic       strapBypass = 1'b0;
  logic       strapDiv2 = 1'b1;
  logic [6:0] strapMulSel = 7'h2B;
  logic [1:0] modeCode;
  logic       pllEnable;
  logic       divEnable;
  logic [6:0] mulValue;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pll_mode_ctrl u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgModeReq(cfgModeReq),
    .cfgPllOff(cfgPllOff), .wakeAsync(wakeAsync), .pllLock(pllLock),
    .strapBypass(strapBypass), .strapDiv2(strapDiv2), .strapMulSel(strapMulSel),
    .modeCode(modeCode), .pllEnable(pllEnable), .divEnable(divEnable),
    .mulValue(mulValue)
  );

  // {wrEn, req[1:0], lock, expMode[1:0], expPllEn}
  localparam logic [6:0] VEC [0:8] = '{
    7'b1_00_0_00_1,  // R5 bypass write clears armed request
    7'b1_01_0_00_1,  // R6 multiply without lock -> pending
    7'b0_00_1_01_1,  // R6 lock completes pending
    7'b1_10_1_10_0,  // R5 loop powerdown
    7'b1_01_0_00_1,  // R6 multiply from loop powerdown, no lock
    7'b0_00_0_00_1,  // R6 still waiting
    7'b0_00_1_01_1,  // R6 lock completes
    7'b1_00_1_00_1,  // R5 back to bypass
    7'b1_01_1_01_1   // R6 direct multiply with lock
  };

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] code, input logic off);
    cfgWrEn = 1'b1; cfgModeReq = code; cfgPllOff = off;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", modeCode, 0, "mode in reset");
    chk("R1", pllEnable, 1, "pllEnable in reset");
    chk("R1", divEnable, 0, "divEnable in reset");
    chk("R1", mulValue, 0, "mulValue in reset");
    rstN = 1'b1;
    @(negedge clk);
    chk("R2", divEnable, 1, "divEnable captured");
    chk("R2", mulValue, 'h2B, "mulValue captured");
    // R7: armed multiply completes on lock
    chk("R7", modeCode, 0, "bypass before lock");
    pllLock = 1'b1;
    @(negedge clk);
    chk("R7", modeCode, 1, "auto multiply on lock");
    pllLock = 1'b0;
    wr(2'b00, 1'b0);
    // R2: strap changes ignored
    strapDiv2 = 1'b0; strapMulSel = 7'h11; strapBypass = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2", divEnable, 1, "divEnable frozen");
    chk("R2", mulValue, 'h2B, "mulValue frozen");

    for (int i = 0; i < 9; i++) begin
      cfgWrEn = VEC[i][6]; cfgModeReq = VEC[i][5:4]; pllLock = VEC[i][3];
      @(negedge clk);
      cfgWrEn = 1'b0;
      chk("R5/R6", modeCode, VEC[i][2:1], $sformatf("vector %0d mode", i));
      chk("R4", pllEnable, VEC[i][0], $sformatf("vector %0d pllEnable", i));
    end

    // R8: full powerdown from multiply, writes ignored
    pllLock = 1'b0;
    wr(2'b11, 1'b0);
    chk("R8", modeCode, 3, "enter full powerdown");
    chk("R4", pllEnable, 0, "loop off in full powerdown");
    wr(2'b00, 1'b1);
    chk("R8", modeCode, 3, "write ignored in full powerdown");
    // R9 timing and R10 was-multiply path
    wakeAsync = 1'b1;
    @(negedge clk);
    chk("R9", modeCode, 3, "one edge after wake");
    @(negedge clk);
    chk("R9", modeCode, 3, "two edges after wake");
    @(negedge clk);
    chk("R9", modeCode, 0, "three edges after wake");
    wakeAsync = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10", modeCode, 0, "bypass awaiting lock");
    pllLock = 1'b1;
    @(negedge clk);
    chk("R10", modeCode, 1, "multiply after lock on wake");

    // R10 off bit = 1 from bypass
    wr(2'b00, 1'b0);
    pllLock = 1'b0;
    wr(2'b11, 1'b1);
    wakeAsync = 1'b1;
    repeat (3) @(negedge clk);
    wakeAsync = 1'b0;
    chk("R10", modeCode, 0, "wake to bypass with off=1");
    pllLock = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10", modeCode, 0, "no multiply without prior multiply");
    pllLock = 1'b0;

    // R10 off bit = 0 from bypass
    wr(2'b11, 1'b0);
    wakeAsync = 1'b1;
    repeat (3) @(negedge clk);
    wakeAsync = 1'b0;
    chk("R10", modeCode, 2, "wake to loop powerdown with off=0");
    chk("R4", pllEnable, 0, "loop off in loop powerdown");

    // R3: bypass strapped
    strapBypass = 1'b1; strapDiv2 = 1'b0; strapMulSel = 7'h55;
    doReset();
    chk("R3", mulValue, 0, "mulValue zero with bypass strap");
    chk("R2", divEnable, 0, "divEnable follows strap");
    pllLock = 1'b1;
    @(negedge clk);
    chk("R3", modeCode, 0, "no auto multiply with bypass strap");
    wr(2'b01, 1'b0);
    chk("R3", modeCode, 0, "multiply request ignored");
    @(negedge clk);
    chk("R3", modeCode, 0, "still bypass");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule